// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block keeps one interrupt flag for each of the two ports of a shared 16K-word memory. The flags change only as a side effect of ordinary memory accesses to two fixed mailbox words at the top of the address space:

- The highest word belongs to the right port.
- The word just below it belongs to the left port.

A port that writes into the other side's mailbox raises that side's interrupt. The owner drops its interrupt by reading its own mailbox. Each port's busy input, which comes from the memory's contention arbiter, stops that port from doing either. The message words themselves live in the RAM and are not modelled here.

Every port presents these signals on each clock cycle:

- an enable;
- a read/write strobe, where high means read;
- an output enable;
- a 14-bit address;
- a busy flag.

Accesses are sampled on the rising clock edge. A flag changes at the edge that samples the qualifying access, so the interrupt pin shows the new level right after that edge. Both interrupt pins are active low. All pins are plain control and status lines, and there is no back-pressure.

Top module: `mbx_irq_flags`

## Requirements
- R1: While reset is low, and after it is released, both interrupt outputs (`lt_irq_n`, `rt_irq_n`) are high.
- R2: A left-port write (enable 1, read/write 0) to address 0x3FFF with left busy low drives `rt_irq_n` low after that clock edge.
- R3: A right-port write to address 0x3FFE with right busy low drives `lt_irq_n` low after that clock edge.
- R4: A right-port read (enable 1, read/write 1, output enable 1) of 0x3FFF with right busy low returns `rt_irq_n` high, unless a set happens in the same cycle.
- R5: A left-port read of 0x3FFE with left busy low returns `lt_irq_n` high, unless a set happens in the same cycle.
- R6: A port reading the other port's mailbox leaves both interrupt outputs unchanged.
- R7: A write by a port whose busy input is high never raises the other side's interrupt.
- R8: A read of its own mailbox by a port whose busy input is high never clears that port's interrupt.
- R9: An access with output enable low does not count as a read. An access with enable low counts as neither a read nor a write.
- R10: When the owner's clearing read and the other port's setting write fall in the same cycle, the flag ends up set (output low).
- R11: With no qualifying set or clear, each flag holds its value. This covers writes to a port's own mailbox and accesses to other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; accesses are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_en | input | 1 | Left port enable, active high |
| lt_rd_nwr | input | 1 | Left read/write strobe: 1 = read, 0 = write |
| lt_oe | input | 1 | Left output enable, active high |
| lt_addr | input | 14 | Left port address |
| lt_busy | input | 1 | Left busy from the arbiter, active high |
| rt_en | input | 1 | Right port enable, active high |
| rt_rd_nwr | input | 1 | Right read/write strobe: 1 = read, 0 = write |
| rt_oe | input | 1 | Right output enable, active high |
| rt_addr | input | 14 | Right port address |
| rt_busy | input | 1 | Right busy from the arbiter, active high |
| lt_irq_n | output | 1 | Left interrupt, low when set |
| rt_irq_n | output | 1 | Right interrupt, low when set |

## Verification
The bench checks the cases below, each against the failure it would expose:

- **Cross-mailbox reads.** A design that decoded the mailbox address without regard to which port is reading would clear a flag when a port reads the other side's word.
- **Reads with output enable low, and writes with enable low.** These catch a decoder that treats any enabled access as a read, or ignores the enable.
- **Busy on both paths.** Busy is raised once during a setting write and once during a clearing read. A design that gated only one path, or used the wrong port's busy, would move a flag.
- **Same-cycle set and clear, on each flag.** A design that let the clear win would leave the interrupt high.
- **Reset mid-run.** Reset is applied after both flags are set, which exposes flags that survive reset.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // Mailbox word owned by a side: right owns the top word, left the one below.
  function automatic int unsigned box_addr(input int unsigned aw, input side_e s);
    int unsigned top;
    top = (32'd1 << aw) - 32'd1;
    return (s == SIDE_LEFT) ? top - 32'd1 : top;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic              en,
  input  logic              rd_nwr,
  input  logic              oe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              set_peer,
  output logic              clr_own
);

  logic rd_cyc;
  logic wr_cyc;

  // A read needs enable, output enable and the strobe high; a write needs
  // enable with the strobe low. Busy from the arbiter blocks both effects.
  always_comb begin
    rd_cyc   = en && rd_nwr && oe;
    wr_cyc   = en && !rd_nwr;
    set_peer = wr_cyc && !busy && (addr == PEER_BOX);
    clr_own  = rd_cyc && !busy && (addr == OWN_BOX);
  end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_n <= 1'b1;
    else if (set) irq_n <= 1'b0;   // set outranks a same-cycle clear
    else if (clr) irq_n <= 1'b1;
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !irq_n);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> irq_n);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lt_en,
  input  logic              lt_rd_nwr,
  input  logic              lt_oe,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic              lt_busy,
  input  logic              rt_en,
  input  logic              rt_rd_nwr,
  input  logic              rt_oe,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              rt_busy,
  output logic              lt_irq_n,
  output logic              rt_irq_n
);
  import mbx_pkg::*;

  localparam int NSIDE = 2;
  localparam logic [ADDR_W-1:0] RBOX = ADDR_W'(box_addr(ADDR_W, SIDE_RIGHT));
  localparam logic [ADDR_W-1:0] LBOX = ADDR_W'(box_addr(ADDR_W, SIDE_LEFT));

  logic [NSIDE-1:0] en_a, rd_a, oe_a, busy_a, set_peer, clr_own, irq_n_a;
  logic [ADDR_W-1:0] addr_a [NSIDE];

  assign en_a   = {rt_en, lt_en};
  assign rd_a   = {rt_rd_nwr, lt_rd_nwr};
  assign oe_a   = {rt_oe, lt_oe};
  assign busy_a = {rt_busy, lt_busy};
  assign addr_a[0] = lt_addr;
  assign addr_a[1] = rt_addr;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam logic [ADDR_W-1:0] OWN  = (s == 0) ? LBOX : RBOX;
    localparam logic [ADDR_W-1:0] PEER = (s == 0) ? RBOX : LBOX;

    mbx_port_decode #(
      .ADDR_W  (ADDR_W),
      .OWN_BOX (OWN),
      .PEER_BOX(PEER)
    ) u_dec (
      .en      (en_a[s]),
      .rd_nwr  (rd_a[s]),
      .oe      (oe_a[s]),
      .busy    (busy_a[s]),
      .addr    (addr_a[s]),
      .set_peer(set_peer[s]),
      .clr_own (clr_own[s])
    );

    // This side's flag is raised by the opposite side's write.
    mbx_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (set_peer[NSIDE-1-s]),
      .clr  (clr_own[s]),
      .irq_n(irq_n_a[s])
    );
  end

  assign lt_irq_n = irq_n_a[0];
  assign rt_irq_n = irq_n_a[1];

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (lt_irq_n && rt_irq_n));

  p_left_sets_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_en && !lt_rd_nwr && !lt_busy && lt_addr == RBOX) |=> !rt_irq_n);

  p_right_sets_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_en && !rt_rd_nwr && !rt_busy && rt_addr == LBOX) |=> !lt_irq_n);

  p_right_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_en && rt_rd_nwr && rt_oe && !rt_busy && rt_addr == RBOX
     && !(lt_en && !lt_rd_nwr && !lt_busy && lt_addr == RBOX)) |=> rt_irq_n);

  p_left_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_en && lt_rd_nwr && lt_oe && !lt_busy && lt_addr == LBOX
     && !(rt_en && !rt_rd_nwr && !rt_busy && rt_addr == LBOX)) |=> lt_irq_n);

  p_busy_no_set_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_busy && rt_irq_n) |=> rt_irq_n);

  p_busy_no_set_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_busy && lt_irq_n) |=> lt_irq_n);

  p_busy_no_clr_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_busy && !lt_irq_n) |=> !lt_irq_n);

  p_busy_no_clr_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_busy && !rt_irq_n) |=> !rt_irq_n);

endmodule

// File: tb/sim_mbx_irq_flags.sv
module sim_mbx_irq_flags;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 14;

  // Port pattern: {en, rd_nwr, oe, busy, addr}
  localparam logic [17:0] IDLE       = 18'h0;
  localparam logic [17:0] WR_RB      = {1'b1, 1'b0, 1'b0, 1'b0, 14'h3FFF};
  localparam logic [17:0] WR_RB_BSY  = {1'b1, 1'b0, 1'b0, 1'b1, 14'h3FFF};
  localparam logic [17:0] WR_RB_NOEN = {1'b0, 1'b0, 1'b0, 1'b0, 14'h3FFF};
  localparam logic [17:0] WR_LB      = {1'b1, 1'b0, 1'b0, 1'b0, 14'h3FFE};
  localparam logic [17:0] WR_LB_BSY  = {1'b1, 1'b0, 1'b0, 1'b1, 14'h3FFE};
  localparam logic [17:0] WR_OTHER   = {1'b1, 1'b0, 1'b0, 1'b0, 14'h3FFD};
  localparam logic [17:0] RD_RB      = {1'b1, 1'b1, 1'b1, 1'b0, 14'h3FFF};
  localparam logic [17:0] RD_RB_NOOE = {1'b1, 1'b1, 1'b0, 1'b0, 14'h3FFF};
  localparam logic [17:0] RD_RB_BSY  = {1'b1, 1'b1, 1'b1, 1'b1, 14'h3FFF};
  localparam logic [17:0] RD_LB      = {1'b1, 1'b1, 1'b1, 1'b0, 14'h3FFE};
  localparam logic [17:0] RD_LB_BSY  = {1'b1, 1'b1, 1'b1, 1'b1, 14'h3FFE};

  // Entry: {req[3:0], left[17:0], right[17:0], exp_lt_irq_n, exp_rt_irq_n}
  localparam int NV = 21;
  localparam logic [41:0] VEC [NV] = '{
    {4'd1,  IDLE,       IDLE,       1'b1, 1'b1},  // R1 idle after reset
    {4'd2,  WR_RB,      IDLE,       1'b1, 1'b0},  // R2 left sets right
    {4'd6,  RD_RB,      IDLE,       1'b1, 1'b0},  // R6 left reads right box
    {4'd9,  IDLE,       RD_RB_NOOE, 1'b1, 1'b0},  // R9 no oe, no clear
    {4'd8,  IDLE,       RD_RB_BSY,  1'b1, 1'b0},  // R8 busy blocks clear
    {4'd4,  IDLE,       RD_RB,      1'b1, 1'b1},  // R4 right clears
    {4'd7,  IDLE,       WR_LB_BSY,  1'b1, 1'b1},  // R7 busy blocks set
    {4'd3,  IDLE,       WR_LB,      1'b0, 1'b1},  // R3 right sets left
    {4'd6,  IDLE,       RD_LB,      1'b0, 1'b1},  // R6 right reads left box
    {4'd11, WR_LB,      IDLE,       1'b0, 1'b1},  // R11 write own box
    {4'd8,  RD_LB_BSY,  IDLE,       1'b0, 1'b1},  // R8 busy blocks clear
    {4'd5,  RD_LB,      IDLE,       1'b1, 1'b1},  // R5 left clears
    {4'd9,  WR_RB_NOEN, IDLE,       1'b1, 1'b1},  // R9 no enable, no set
    {4'd11, WR_OTHER,   WR_OTHER,   1'b1, 1'b1},  // R11 other address
    {4'd7,  WR_RB_BSY,  IDLE,       1'b1, 1'b1},  // R7 left busy blocks set
    {4'd2,  WR_RB,      IDLE,       1'b1, 1'b0},  // R2 set again
    {4'd10, WR_RB,      RD_RB,      1'b1, 1'b0},  // R10 set beats clear
    {4'd10, RD_LB,      WR_LB,      1'b0, 1'b0},  // R10 set beats clear
    {4'd11, IDLE,       IDLE,       1'b0, 1'b0},  // R11 hold
    {4'd4,  IDLE,       RD_RB,      1'b0, 1'b1},  // R4
    {4'd5,  RD_LB,      IDLE,       1'b1, 1'b1}   // R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [17:0] lp = '0;
  logic [17:0] rp = '0;
  logic lt_irq_n, rt_irq_n;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_irq_flags #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lt_en(lp[17]), .lt_rd_nwr(lp[16]), .lt_oe(lp[15]), .lt_busy(lp[14]), .lt_addr(lp[13:0]),
    .rt_en(rp[17]), .rt_rd_nwr(rp[16]), .rt_oe(rp[15]), .rt_busy(rp[14]), .rt_addr(rp[13:0]),
    .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
  );

  task automatic check(input int req, input logic [1:0] exp);
    checks++;
    if ({lt_irq_n, rt_irq_n} !== exp) begin
      fails++;
      $display("FAIL R%0d: {lt_irq_n,rt_irq_n} actual=%b expected=%b", req, {lt_irq_n, rt_irq_n}, exp);
    end
  endtask

  task automatic apply(input logic [17:0] l, input logic [17:0] r);
    @(negedge clk);
    lp = l;
    rp = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1, 2'b11);  // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][37:20], VEC[i][19:2]);
      check(int'(VEC[i][41:38]), VEC[i][1:0]);
    end
    // R11: flags hold over idle cycles once set
    apply(WR_RB, WR_LB);
    check(2, 2'b00);
    for (int k = 0; k < 4; k++) apply(IDLE, IDLE);
    check(11, 2'b00);
    // R1: reset in mid-run releases both flags
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(1, 2'b11);
    @(negedge clk);
    rst_n = 1'b1;
    apply(IDLE, IDLE);
    check(1, 2'b11);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule